// File: doc/BRIEF.md
# Serial Audio Transmitter for External Converters

This block sends stereo 16-bit samples to an external digital-to-analog converter over three wires: a bit clock, a word clock and a serial data line. A frame is one word-clock period and holds 32 bit slots. The first 16 slots carry the left sample and the next 16 carry the right sample. A serial audio format code picks the bit order and the framing. Code 00 sends the most significant bit first. Code 01 sends the least significant bit first. Code 11 sends the most significant bit first, inverts the word clock and delays the data by one bit slot. Before a sample is shifted out, it is recoded to offset binary or left as two's complement. In mono mode the left sample fills both halves of the frame.

In master mode the block makes its own bit clock: each pulse of a system-clock enable toggles it. The block also drives the word clock. In slave mode it takes both clocks from outside through a synchronizer. It starts a frame when the word clock changes into its left-channel level. If that change does not come, the shift register rotates and the last frame is sent again. When the external-converter enable is low, the port is idle and its state is cleared.

Top module: `audio_ser_tx`

## Requirements
- R1: A frame has 32 bit slots. Left occupies slots 0 to 15 and right occupies slots 16 to 31. For codes 00, 01 and 10 the master word clock is 1 during left slots and 0 during right slots. After reset with the port enabled, all three outputs are 0.
- R2: With code 00, each channel is sent most significant bit first. Code 10 behaves exactly like code 00.
- R3: With code 01, each channel is sent least significant bit first.
- R4: With code 11, the word clock is 0 during left slots. The data line in slot s carries the bit that code 00 would place in slot s-1. Slot 0 carries the last bit of the previous frame, which is 0 after reset or re-enable.
- R5: In master mode, the bit clock toggles once per `bit_tick` pulse. Data and word clock change only together with a falling bit clock. The receiver samples data on the rising bit clock.
- R6: In slave mode, `sclk_out` and `wclk_out` stay 0 and `bit_tick` has no effect. Data shifts on falling edges of `sclk_in`. A frame starts when `wclk_in` changes into its left level: 1 for codes 00, 01 and 10, and 0 for code 11.
- R7: In slave mode, if the left-level word-clock change is missing, the previous frame is sent again unchanged, even when the input samples have changed.
- R8: While `ext_en` is 0, all outputs stay 0. Clock, slot and shift state are cleared.
- R9: With `offset_bin` set to 1, bit 15 of each sample is inverted before it is sent. With `offset_bin` set to 0, the two's complement value is sent unchanged.
- R10: With `mono` set to 1, the left sample is sent in both the left and the right half of the frame.
- R11: Both samples are captured when a frame starts. Input changes during the frame do not affect that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_en | input | 1 | External converter port enable |
| slave_mode | input | 1 | 0: master, drives clocks; 1: slave, follows external clocks |
| fmt | input | 2 | Serial format code (00 MSB first, 01 LSB first, 11 delayed/inverted, 10 as 00) |
| offset_bin | input | 1 | 1: offset binary output coding; 0: two's complement |
| mono | input | 1 | Send the left sample on both channels |
| left_smp | input | 16 | Left channel sample |
| right_smp | input | 16 | Right channel sample |
| bit_tick | input | 1 | Master bit-clock half-period enable |
| sclk_in | input | 1 | External bit clock (slave) |
| wclk_in | input | 1 | External word clock (slave) |
| sclk_out | output | 1 | Generated bit clock (master) |
| wclk_out | output | 1 | Generated word clock (master) |
| sdata | output | 1 | Serial data |

## Verification
The clocking properties only hold when the mode inputs stay stable. They are checked only in cycles where `ext_en`, `slave_mode` and `fmt` have not changed since the previous cycle. The stimulus changes these inputs only between frames, with no bit-clock activity around the change. In slave mode, the external clocks are held for several system clocks per half period, which is longer than the synchronizer latency. The word clock always changes at the same time as a falling bit clock, as the frame-start rule assumes.

// File: rtl/aso_pkg.sv
package aso_pkg;
  localparam int unsigned SMP_W   = 16;
  localparam int unsigned FRAME_W = 2 * SMP_W;

  typedef enum logic [1:0] {
    FMT_MSB = 2'b00,
    FMT_LSB = 2'b01,
    FMT_RSV = 2'b10,
    FMT_DLY = 2'b11
  } fmt_e;

  // Output coding: offset binary flips the sign bit.
  function automatic logic [SMP_W-1:0] recode(input logic [SMP_W-1:0] s, input logic offb);
    return offb ? {~s[SMP_W-1], s[SMP_W-2:0]} : s;
  endfunction

  function automatic logic [SMP_W-1:0] bitrev(input logic [SMP_W-1:0] s);
    logic [SMP_W-1:0] r;
    for (int i = 0; i < int'(SMP_W); i++) r[i] = s[SMP_W-1-i];
    return r;
  endfunction

  // Word clock level that marks the left half of a frame.
  function automatic logic left_level(input fmt_e f);
    return f != FMT_DLY;
  endfunction

  // Frame word, shifted out from its top bit.
  function automatic logic [FRAME_W-1:0] frame_word(input logic [SMP_W-1:0] l,
                                                    input logic [SMP_W-1:0] r,
                                                    input fmt_e f, input logic offb,
                                                    input logic mono);
    logic [SMP_W-1:0] lc, rc;
    lc = recode(l, offb);
    rc = recode(mono ? l : r, offb);
    if (f == FMT_LSB) begin
      lc = bitrev(lc);
      rc = bitrev(rc);
    end
    return {lc, rc};
  endfunction
endpackage

// File: rtl/aso_bclk_gen.sv
module aso_bclk_gen (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic tick,
  output logic bclk,
  output logic fall_ev
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    bclk <= 1'b0;
    else if (clr)  bclk <= 1'b0;
    else if (tick) bclk <= ~bclk;
  end

  assign fall_ev = tick & bclk & ~clr;
endmodule

// File: rtl/aso_slave_sync.sv
module aso_slave_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic sclk_in,
  input  logic wclk_in,
  output logic fall_ev,
  output logic wclk_s
);
  logic [STAGES-1:0] s_sh, w_sh;
  logic              s_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s_sh   <= '0;
      w_sh   <= '0;
      s_prev <= 1'b0;
    end else begin
      s_sh   <= {s_sh[STAGES-2:0], sclk_in};
      w_sh   <= {w_sh[STAGES-2:0], wclk_in};
      s_prev <= clr ? 1'b0 : s_sh[STAGES-1];
    end
  end

  assign fall_ev = ~clr & s_prev & ~s_sh[STAGES-1];
  assign wclk_s  = w_sh[STAGES-1];
endmodule

// File: rtl/aso_shifter.sv
module aso_shifter #(
  parameter int unsigned FRAME_W = 32,
  localparam int unsigned SLOT_W = $clog2(FRAME_W)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clr,
  input  logic               shift_ev,
  input  logic               load_ev,
  input  logic [FRAME_W-1:0] frame_in,
  input  logic               dly_sel,
  output logic               sdata,
  output logic [SLOT_W-1:0]  slot
);
  localparam logic [SLOT_W-1:0] LAST = SLOT_W'(FRAME_W - 1);

  logic [FRAME_W-1:0] sreg;
  logic               dly_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sreg  <= '0;
      dly_q <= 1'b0;
      slot  <= LAST;
    end else if (clr) begin
      sreg  <= '0;
      dly_q <= 1'b0;
      slot  <= LAST;
    end else if (shift_ev) begin
      dly_q <= sreg[FRAME_W-1];
      if (load_ev) begin
        sreg <= frame_in;
        slot <= '0;
      end else begin
        // rotation makes a frame without a new start repeat itself
        sreg <= {sreg[FRAME_W-2:0], sreg[FRAME_W-1]};
        slot <= (slot == LAST) ? '0 : slot + 1'b1;
      end
    end
  end

  assign sdata = dly_sel ? dly_q : sreg[FRAME_W-1];
endmodule

// File: rtl/audio_ser_tx.sv
module audio_ser_tx
  import aso_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ext_en,
  input  logic             slave_mode,
  input  logic [1:0]       fmt,
  input  logic             offset_bin,
  input  logic             mono,
  input  logic [SMP_W-1:0] left_smp,
  input  logic [SMP_W-1:0] right_smp,
  input  logic             bit_tick,
  input  logic             sclk_in,
  input  logic             wclk_in,
  output logic             sclk_out,
  output logic             wclk_out,
  output logic             sdata
);
  localparam int unsigned SLOT_W = $clog2(FRAME_W);
  localparam logic [SLOT_W-1:0] HALF = SLOT_W'(SMP_W);
  localparam logic [SLOT_W-1:0] LAST = SLOT_W'(FRAME_W - 1);

  fmt_e fmt_c;
  logic master, clr, lvl_left;
  logic bclk, m_fall, s_fall, wclk_s, wprev;
  logic shift_ev, load_ev, s_edge, sh_data;
  logic [SLOT_W-1:0]  slot;
  logic [FRAME_W-1:0] frame_in;

  assign fmt_c    = fmt_e'(fmt);
  assign master   = ext_en & ~slave_mode;
  assign clr      = ~ext_en;
  assign lvl_left = left_level(fmt_c);

  aso_bclk_gen u_bclk (
    .clk(clk), .rst_n(rst_n), .clr(~master), .tick(bit_tick),
    .bclk(bclk), .fall_ev(m_fall)
  );

  aso_slave_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .clr(~(ext_en & slave_mode)),
    .sclk_in(sclk_in), .wclk_in(wclk_in), .fall_ev(s_fall), .wclk_s(wclk_s)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      wprev <= 1'b0;
    else if (clr)    wprev <= 1'b0;
    else if (s_fall) wprev <= wclk_s;
  end

  assign s_edge   = (wclk_s != wprev) && (wclk_s == lvl_left);
  assign shift_ev = slave_mode ? s_fall : m_fall;
  assign load_ev  = shift_ev & (slave_mode ? s_edge : (slot == LAST));
  assign frame_in = frame_word(left_smp, right_smp, fmt_c, offset_bin, mono);

  aso_shifter #(.FRAME_W(FRAME_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .clr(clr), .shift_ev(shift_ev), .load_ev(load_ev),
    .frame_in(frame_in), .dly_sel(fmt_c == FMT_DLY), .sdata(sh_data), .slot(slot)
  );

  assign sclk_out = master & bclk;
  assign wclk_out = master & ((slot < HALF) == lvl_left);
  assign sdata    = ext_en & sh_data;
endmodule

// File: rtl/aso_chk.sv
module aso_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       ext_en,
  input logic       slave_mode,
  input logic       bit_tick,
  input logic [1:0] fmt,
  input logic       sclk_out,
  input logic       wclk_out,
  input logic       sdata
);
  logic steady;
  assign steady = ext_en && !slave_mode;

  // R8
  idle_outputs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ext_en |-> (!sclk_out && !wclk_out && !sdata));

  // R6
  slave_clocks_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    slave_mode |-> (!sclk_out && !wclk_out));

  // R5
  bclk_follows_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (steady && $past(steady) && !$stable(sclk_out)) |-> $past(bit_tick));

  // R5
  data_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (steady && $past(steady) && $stable(fmt) && !$stable(sdata)) |-> $fell(sclk_out));

  // R1
  wclk_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (steady && $past(steady) && $stable(fmt) && !$stable(wclk_out)) |-> $fell(sclk_out));
endmodule

bind audio_ser_tx aso_chk chk_i (
  .clk(clk), .rst_n(rst_n), .ext_en(ext_en), .slave_mode(slave_mode),
  .bit_tick(bit_tick), .fmt(fmt), .sclk_out(sclk_out), .wclk_out(wclk_out),
  .sdata(sdata)
);

// File: tb/audio_ser_tx_tb_top.sv
module audio_ser_tx_tb_top;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n, ext_en, slave_mode, offset_bin, mono, bit_tick, sclk_in, wclk_in;
  logic [1:0]  fmt;
  logic [15:0] left_smp, right_smp;
  logic sclk_out, wclk_out, sdata;

  int n_chk = 0, n_fail = 0;
  logic prev_raw = 1'b0;
  logic tog_ok;

  audio_ser_tx dut_i (
    .clk(clk), .rst_n(rst_n), .ext_en(ext_en), .slave_mode(slave_mode), .fmt(fmt),
    .offset_bin(offset_bin), .mono(mono), .left_smp(left_smp), .right_smp(right_smp),
    .bit_tick(bit_tick), .sclk_in(sclk_in), .wclk_in(wclk_in),
    .sclk_out(sclk_out), .wclk_out(wclk_out), .sdata(sdata)
  );

  task automatic check(input logic ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Undelayed bit stream, index = slot number.
  function automatic logic [31:0] raw_stream(input logic [15:0] l, input logic [15:0] r,
                                             input logic [1:0] f, input logic ob,
                                             input logic mo);
    logic [31:0] e;
    for (int s = 0; s < 32; s++) begin
      logic [15:0] ch;
      int k;
      ch = (s < 16 || mo) ? l : r;
      if (ob) ch = ch ^ 16'h8000;
      k = s % 16;
      e[s] = (f == 2'b01) ? ch[k] : ch[15-k];
    end
    return e;
  endfunction

  function automatic logic [31:0] wclk_pattern(input logic [1:0] f);
    logic [31:0] w;
    for (int s = 0; s < 32; s++) w[s] = (s < 16) ^ (f == 2'b11);
    return w;
  endfunction

  task automatic tick(input logic exp_sclk);
    @(negedge clk) bit_tick = 1'b1;
    @(negedge clk) bit_tick = 1'b0;
    if (sclk_out !== exp_sclk) tog_ok = 1'b0;
  endtask

  task automatic master_frame(input logic [15:0] l, input logic [15:0] r,
                              input logic [1:0] f, input logic ob, input logic mo,
                              input logic scramble, input string tag);
    logic [31:0] got, gw, raw, exp;
    @(negedge clk);
    left_smp = l; right_smp = r; fmt = f; offset_bin = ob; mono = mo;
    tog_ok = 1'b1;
    for (int s = 0; s < 32; s++) begin
      tick(1'b0);
      if (scramble && s == 2) begin
        left_smp = 16'($urandom); right_smp = 16'($urandom);
      end
      tick(1'b1);
      got[s] = sdata;
      gw[s]  = wclk_out;
    end
    raw = raw_stream(l, r, f, ob, mo);
    exp = (f == 2'b11) ? {raw[30:0], prev_raw} : raw;
    prev_raw = raw[31];
    check(got == exp, tag, got, exp);
    check(gw == wclk_pattern(f), "R1 word clock", gw, wclk_pattern(f));
    check(tog_ok, "R5 bit clock toggle", {31'd0, tog_ok}, 32'd1);
  endtask

  task automatic slave_frame(input logic [15:0] l, input logic [15:0] r,
                             input logic good_wclk, output logic [31:0] got,
                             output logic quiet);
    @(negedge clk);
    left_smp = l; right_smp = r;
    quiet = 1'b1;
    for (int s = 0; s < 32; s++) begin
      @(negedge clk);
      sclk_in = 1'b0;
      wclk_in = good_wclk ? (s < 16) : 1'b0;
      bit_tick = 1'b1;
      repeat (6) @(negedge clk);
      bit_tick = 1'b0;
      sclk_in = 1'b1;
      repeat (6) @(negedge clk);
      got[s] = sdata;
      if (sclk_out !== 1'b0 || wclk_out !== 1'b0) quiet = 1'b0;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++; n_chk++;
    $display("FAIL R1 watchdog actual=%h expected=%h", 0, 1);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [31:0] g1, g2, g3, e1, e3;
    logic q1, q2, q3;
    void'($urandom(32'h5EED_0A17));
    rst_n = 0; ext_en = 1; slave_mode = 0; fmt = 0; offset_bin = 0; mono = 0;
    left_smp = 0; right_smp = 0; bit_tick = 0; sclk_in = 1; wclk_in = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    check({sclk_out, wclk_out, sdata} == 3'b000, "R1 reset outputs",
          {29'd0, sclk_out, wclk_out, sdata}, 32'd0);
    tog_ok = 1'b1;
    tick(1'b1);

    master_frame(16'hA5C3, 16'h1234, 2'b00, 0, 0, 0, "R2 msb first");
    master_frame(16'h8001, 16'h7FFE, 2'b10, 0, 0, 0, "R2 code 10 as 00");
    master_frame(16'hA5C3, 16'h1234, 2'b01, 0, 0, 0, "R3 lsb first");
    master_frame(16'hF00F, 16'h0001, 2'b11, 0, 0, 0, "R4 delayed");
    master_frame(16'h4002, 16'hC003, 2'b11, 0, 0, 0, "R4 delayed carry");
    master_frame(16'h0000, 16'hFFFF, 2'b00, 1, 0, 0, "R9 offset binary");
    master_frame(16'h8000, 16'h7FFF, 2'b00, 0, 0, 0, "R9 twos complement");
    master_frame(16'h3C5A, 16'hFFFF, 2'b01, 0, 1, 0, "R10 mono");
    master_frame(16'h9111, 16'h2222, 2'b00, 0, 0, 1, "R11 capture at frame start");

    for (int i = 0; i < 40; i++) begin
      logic [1:0] f;
      string tag;
      f = 2'($urandom);
      tag = (f == 2'b01) ? "R3/R11 random" : (f == 2'b11) ? "R4/R11 random" : "R2/R11 random";
      master_frame(16'($urandom), 16'($urandom), f, 1'($urandom), 1'($urandom), 1, tag);
    end

    // R8 disable
    @(negedge clk) ext_en = 0;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk) bit_tick = 1;
      @(negedge clk) bit_tick = 0;
      check({sclk_out, wclk_out, sdata} == 3'b000, "R8 idle while disabled",
            {29'd0, sclk_out, wclk_out, sdata}, 32'd0);
    end
    @(negedge clk) ext_en = 1;
    prev_raw = 1'b0;
    tog_ok = 1'b1;
    tick(1'b1);
    master_frame(16'h0001, 16'h8000, 2'b11, 0, 0, 0, "R8/R4 cleared after re-enable");

    // R6/R7 slave
    @(negedge clk) slave_mode = 1; fmt = 2'b00; offset_bin = 0; mono = 0;
    sclk_in = 1; wclk_in = 0;
    repeat (8) @(negedge clk);
    slave_frame(16'hBEEF, 16'h0F0F, 1, g1, q1);
    slave_frame(16'h1357, 16'h2468, 0, g2, q2);
    slave_frame(16'hC001, 16'h7E7E, 1, g3, q3);
    e1 = raw_stream(16'hBEEF, 16'h0F0F, 2'b00, 0, 0);
    e3 = raw_stream(16'hC001, 16'h7E7E, 2'b00, 0, 0);
    check(g1 == e1, "R6 slave frame", g1, e1);
    check(g2 == e1, "R7 missing edge repeats", g2, e1);
    check(g3 == e3, "R6 slave new frame", g3, e3);
    check(q1 && q2 && q3, "R6 slave clocks quiet", {31'd0, q1 & q2 & q3}, 32'd1);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule